// File: doc/BRIEF.md
# Vector Element Issue Sequencer

This decode-stage controller takes one instruction bundle at a time and turns it into issue groups of up to six element operations. A scalar bundle becomes a single group with all six lanes live. A vector instruction becomes a series of groups. On acceptance the sequencer captures the start indices of the source, target and destination registers, the immediate/address offset, and the element count from the vector length input. It then holds fetch while it walks through the elements.

For each group it presents per-lane register addresses, the current offset and a lane-valid mask. Between groups the register indices advance by six and the offset advances by sixteen. The last group masks off the lanes that lie beyond the element count. A vector length of zero retires the instruction at once and issues nothing.

Both data edges use valid/ready. The instruction input is accepted only while no group is pending: `in_ready` is low from acceptance until the final group has been taken. Downstream back-pressure (`out_ready` low) freezes every group output until the group is taken. The upstream side must keep its bundle steady while `in_valid` is high and `in_ready` is low. `vlen` and `fetch_stall` are plain control pins. `vlen` is sampled in the acceptance cycle.

Top module: `vec_issue_seq`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `fetch_stall` is 0.
- R2: The first group of an accepted instruction carries the accepted RS, RT and RD start indices as lane-0 addresses, and the accepted immediate as `out_imm`.
- R3: A vector instruction of length N (N > 0) yields exactly ceil(N/6) groups. `out_last` is 1 on the final group only. In the cycle after the final group is taken, `out_valid` is 0.
- R4: After each group taken that is not the final one, the RS, RT and RD base indices each grow by 6, wrapping modulo 64.
- R5: After each group taken that is not the final one, `out_imm` grows by 16, wrapping modulo 2^32.
- R6: Bit k of `out_lane_mask` marks lane k live. Every group except the final one has all six bits set. The final group has the low r bits set, where r is the number of elements still outstanding.
- R7: Lane k's address in each of `out_rs_addr`, `out_rt_addr` and `out_rd_addr` sits at bits [6k+5:6k] and equals the group base plus k, modulo 64.
- R8: While a vector instruction has groups pending, `fetch_stall` is 1 and `in_ready` is 0.
- R9: A scalar bundle (`in_is_vec` = 0) yields one group with mask 6'b111111 and `out_last` = 1, whatever the value of `vlen`. `fetch_stall` stays 0 for it.
- R10: A vector instruction with `vlen` = 0 issues no group. In the next cycle `in_ready` is 1 and `fetch_stall` is 0.
- R11: While `out_valid` is 1 and `out_ready` is 0, every group output keeps its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction bundle offered |
| in_ready | output | 1 | Sequencer can accept a bundle |
| in_is_vec | input | 1 | 1 for vector instruction, 0 for scalar bundle |
| in_rs_idx | input | 6 | Source register start index |
| in_rt_idx | input | 6 | Target register start index |
| in_rd_idx | input | 6 | Destination register start index |
| in_imm | input | 32 | Immediate / address offset |
| vlen | input | 7 | Element count from the vector length register (0..64) |
| out_valid | output | 1 | Issue group present |
| out_ready | input | 1 | Downstream takes the group |
| out_is_vec | output | 1 | Group belongs to a vector instruction |
| out_last | output | 1 | Final group of the instruction |
| out_lane_mask | output | 6 | Per-lane valid (write enable) mask |
| out_rs_addr | output | 36 | Six packed 6-bit source addresses |
| out_rt_addr | output | 36 | Six packed 6-bit target addresses |
| out_rd_addr | output | 36 | Six packed 6-bit destination addresses |
| out_imm | output | 32 | Offset for this group |
| fetch_stall | output | 1 | Hold fetch while a vector instruction is issuing |

## Verification
The hardest case to reach is a final group whose lanes are only partly live, presented while downstream is stalled. Only here do a partial mask and output stability have to hold together. The stimulus sweeps every vector length from 0 to 64, which produces every possible remainder. It stalls the output for a cycle on a pattern tied to group number and length, so the final group is held on many of the lengths. The start indices and immediate are also chosen near the top of their ranges, so that wrapping is forced inside a single instruction.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int DEF_LANES    = 6;
  localparam int DEF_IDXW     = 6;
  localparam int DEF_IMMW     = 32;
  localparam int DEF_IMM_STEP = 16;
  localparam int DEF_MAX_VLEN = 64;

  typedef enum logic {
    KIND_SCALAR = 1'b0,
    KIND_VECTOR = 1'b1
  } bundle_kind_e;
endpackage

// File: rtl/vseq_step_ctr.sv
module vseq_step_ctr #(
  parameter int W    = 6,
  parameter int STEP = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] STEP_W = W'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= q + STEP_W;
  end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int VLW   = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_is_vec,
  input  logic [VLW-1:0] vlen,
  input  logic           out_ready,
  output logic           in_ready,
  output logic           out_valid,
  output logic           load,
  output logic           step,
  output logic           is_vec,
  output logic           last,
  output logic [VLW-1:0] rem
);
  localparam logic [VLW-1:0] LANES_V = VLW'(LANES);

  logic         busy_q;
  bundle_kind_e kind_q;
  logic         fire;

  assign in_ready  = !busy_q;
  assign out_valid = busy_q;
  assign load      = in_valid && in_ready;
  assign fire      = busy_q && out_ready;
  assign last      = (rem <= LANES_V);
  assign step      = fire && !last;
  assign is_vec    = (kind_q == KIND_VECTOR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= KIND_SCALAR;
      rem    <= '0;
    end else if (load) begin
      kind_q <= in_is_vec ? KIND_VECTOR : KIND_SCALAR;
      rem    <= in_is_vec ? vlen : LANES_V;
      busy_q <= in_is_vec ? (vlen != '0) : 1'b1;
    end else if (fire) begin
      if (last) busy_q <= 1'b0;
      else      rem    <= rem - LANES_V;
    end
  end

  // R3
  last_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && last) |=> !out_valid);

  // R10
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_is_vec && vlen == '0) |=> (!out_valid && in_ready));
endmodule

// File: rtl/vseq_lane_map.sv
module vseq_lane_map #(
  parameter int LANES = 6,
  parameter int IDXW  = 6,
  parameter int VLW   = 7
) (
  input  logic [VLW-1:0]        rem,
  input  logic [IDXW-1:0]       rs_base,
  input  logic [IDXW-1:0]       rt_base,
  input  logic [IDXW-1:0]       rd_base,
  output logic [LANES-1:0]      mask,
  output logic [LANES*IDXW-1:0] rs_addr,
  output logic [LANES*IDXW-1:0] rt_addr,
  output logic [LANES*IDXW-1:0] rd_addr
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask[l]                   = (rem > VLW'(l));
    assign rs_addr[l*IDXW +: IDXW]   = rs_base + IDXW'(l);
    assign rt_addr[l*IDXW +: IDXW]   = rt_base + IDXW'(l);
    assign rd_addr[l*IDXW +: IDXW]   = rd_base + IDXW'(l);
  end
endmodule

// File: rtl/vec_issue_seq.sv
module vec_issue_seq
  import vseq_pkg::*;
#(
  parameter int LANES    = DEF_LANES,
  parameter int IDXW     = DEF_IDXW,
  parameter int IMMW     = DEF_IMMW,
  parameter int IMM_STEP = DEF_IMM_STEP,
  parameter int MAX_VLEN = DEF_MAX_VLEN,
  localparam int VLW     = $clog2(MAX_VLEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  in_is_vec,
  input  logic [IDXW-1:0]       in_rs_idx,
  input  logic [IDXW-1:0]       in_rt_idx,
  input  logic [IDXW-1:0]       in_rd_idx,
  input  logic [IMMW-1:0]       in_imm,
  input  logic [VLW-1:0]        vlen,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic                  out_is_vec,
  output logic                  out_last,
  output logic [LANES-1:0]      out_lane_mask,
  output logic [LANES*IDXW-1:0] out_rs_addr,
  output logic [LANES*IDXW-1:0] out_rt_addr,
  output logic [LANES*IDXW-1:0] out_rd_addr,
  output logic [IMMW-1:0]       out_imm,
  output logic                  fetch_stall
);
  localparam int NIDX = 3;

  logic           load, step;
  logic [VLW-1:0] rem;
  logic [IDXW-1:0] idx_start [NIDX];
  logic [IDXW-1:0] idx_base  [NIDX];

  assign idx_start[0] = in_rs_idx;
  assign idx_start[1] = in_rt_idx;
  assign idx_start[2] = in_rd_idx;

  vseq_ctrl #(.LANES(LANES), .VLW(VLW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_vec(in_is_vec),
    .vlen(vlen), .out_ready(out_ready), .in_ready(in_ready),
    .out_valid(out_valid), .load(load), .step(step), .is_vec(out_is_vec),
    .last(out_last), .rem(rem)
  );

  for (genvar k = 0; k < NIDX; k++) begin : g_idx
    vseq_step_ctr #(.W(IDXW), .STEP(LANES)) u_idx_ctr (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .load_val(idx_start[k]), .q(idx_base[k])
    );
  end

  vseq_step_ctr #(.W(IMMW), .STEP(IMM_STEP)) u_imm_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .load_val(in_imm), .q(out_imm)
  );

  vseq_lane_map #(.LANES(LANES), .IDXW(IDXW), .VLW(VLW)) u_map (
    .rem(rem), .rs_base(idx_base[0]), .rt_base(idx_base[1]),
    .rd_base(idx_base[2]), .mask(out_lane_mask), .rs_addr(out_rs_addr),
    .rt_addr(out_rt_addr), .rd_addr(out_rd_addr)
  );

  assign fetch_stall = out_valid && out_is_vec;

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lane_mask) &&
      $stable(out_rs_addr) && $stable(out_rt_addr) && $stable(out_rd_addr) &&
      $stable(out_imm) && $stable(out_last)));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_rs_addr[IDXW-1:0] == $past(out_rs_addr[IDXW-1:0]) + IDXW'(LANES)));

  // R5
  imm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_imm == $past(out_imm) + IMMW'(IMM_STEP)));

  // R6
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_lane_mask == '1));

  // R6
  live_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lane_mask[0]);

  // R9
  scalar_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_vec) |-> (out_last && out_lane_mask == '1 && !fetch_stall));

  // R8
  stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> !in_ready);
endmodule

// File: tb/test_vec_issue_seq.sv
`timescale 1ns/1ps
module test_vec_issue_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_is_vec;
  logic [5:0]  in_rs_idx, in_rt_idx, in_rd_idx;
  logic [31:0] in_imm;
  logic [6:0]  vlen;
  logic        out_valid, out_ready, out_is_vec, out_last;
  logic [5:0]  out_lane_mask;
  logic [35:0] out_rs_addr, out_rt_addr, out_rd_addr;
  logic [31:0] out_imm;
  logic        fetch_stall;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  vec_issue_seq i_vec_issue_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_vec(in_is_vec), .in_rs_idx(in_rs_idx), .in_rt_idx(in_rt_idx),
    .in_rd_idx(in_rd_idx), .in_imm(in_imm), .vlen(vlen),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_vec(out_is_vec),
    .out_last(out_last), .out_lane_mask(out_lane_mask),
    .out_rs_addr(out_rs_addr), .out_rt_addr(out_rt_addr),
    .out_rd_addr(out_rd_addr), .out_imm(out_imm), .fetch_stall(fetch_stall)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "R3", "watchdog cycles", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic check_group(input bit vec, input int g, input int n,
                             input int rs, input int rt, input int rd,
                             input logic [31:0] imm);
    int rem;
    logic [5:0] emask;
    rem   = vec ? n - 6 * g : 6;
    emask = (rem >= 6) ? 6'h3F : 6'((1 << rem) - 1);
    chk(out_valid == 1'b1, "R3", "out_valid", out_valid, 1);
    chk(out_last == (rem <= 6), "R3", "out_last", out_last, rem <= 6);
    chk(out_lane_mask == emask, vec ? "R6" : "R9", "mask", out_lane_mask, emask);
    chk(out_imm == imm + 32'(16 * g), g == 0 ? "R2" : "R5", "imm",
        out_imm, imm + 32'(16 * g));
    for (int l = 0; l < 6; l++) begin
      logic [5:0] ers, ert, erd;
      ers = 6'(rs + 6 * g + l);
      ert = 6'(rt + 6 * g + l);
      erd = 6'(rd + 6 * g + l);
      chk(out_rs_addr[l*6 +: 6] == ers, l == 0 ? (g == 0 ? "R2" : "R4") : "R7",
          "rs addr", out_rs_addr[l*6 +: 6], ers);
      chk(out_rt_addr[l*6 +: 6] == ert, l == 0 ? (g == 0 ? "R2" : "R4") : "R7",
          "rt addr", out_rt_addr[l*6 +: 6], ert);
      chk(out_rd_addr[l*6 +: 6] == erd, l == 0 ? (g == 0 ? "R2" : "R4") : "R7",
          "rd addr", out_rd_addr[l*6 +: 6], erd);
    end
    chk(fetch_stall == vec, vec ? "R8" : "R9", "fetch_stall", fetch_stall, vec);
    chk(in_ready == 1'b0, "R8", "in_ready busy", in_ready, 0);
  endtask

  task automatic run_instr(input bit vec, input int n, input int rs,
                           input int rt, input int rd, input logic [31:0] imm);
    int groups;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", "in_ready idle", in_ready, 1);
    in_valid = 1'b1; in_is_vec = vec; vlen = 7'(n);
    in_rs_idx = 6'(rs); in_rt_idx = 6'(rt); in_rd_idx = 6'(rd); in_imm = imm;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; vlen = 7'd5;
    groups = vec ? (n + 5) / 6 : 1;
    for (int g = 0; g < groups; g++) begin
      check_group(vec, g, n, rs, rt, rd, imm);
      if (((g + n) % 3) == 1) begin
        @(negedge clk);
        check_group(vec, g, n, rs, rt, rd, imm); // R11 held group unchanged
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(out_valid == 1'b0, vec && n == 0 ? "R10" : "R3", "out_valid after", out_valid, 0);
    chk(in_ready == 1'b1, vec && n == 0 ? "R10" : "R3", "in_ready after", in_ready, 1);
    chk(fetch_stall == 1'b0, "R10", "fetch_stall after", fetch_stall, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_is_vec = 1'b0; out_ready = 1'b0;
    in_rs_idx = '0; in_rt_idx = '0; in_rd_idx = '0; in_imm = '0; vlen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready reset", in_ready, 1);
    chk(fetch_stall == 1'b0, "R1", "fetch_stall reset", fetch_stall, 0);

    for (int n = 0; n <= 64; n++)
      run_instr(1'b1, n, (n * 7) % 64, (n * 13 + 1) % 64, 63 - n,
                32'hFFFF_FF00 + 32'(n * 3));
    run_instr(1'b0, 30, 62, 5, 60, 32'h0000_1234); // R9 scalar ignores vlen
    run_instr(1'b0, 0, 1, 2, 3, 32'hFFFF_FFF8);    // R9
    run_instr(1'b1, 64, 59, 63, 58, 32'hFFFF_FFF0); // R4 R5 wrap
    run_instr(1'b1, 0, 10, 20, 30, 32'h10);         // R10 zero length
    summary();
    $finish;
  end
endmodule